// File: doc/BRIEF.md
# Flash Unlock and Erase Sequencer

This block sits between a host-side controller and a byte-wide debug register-access port of a target microcontroller. On request it unlocks the target's flash programming engine: it selects the programming control register, writes two keycodes, and then waits a long, parameterised settle interval before it reports flash access as enabled. A later erase request runs the full-device erase handshake. The block selects the programming data register, sends the erase command byte, polls the target's status flags and checks a status byte. It then sends a three-byte arming sequence, polling after each byte, and waits for the final completion flag.

The downstream side is a request/acknowledge port carrying one of three primitives (address-register write, data-register write, data-register read), plus two level status inputs from the target: input-busy and output-ready. Every poll has a cycle-count limit. On the upstream side, single-cycle request pulses start work. Completion of each request is reported by a one-cycle `done` pulse with a 2-bit result code, which holds until the next completion.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `busy`, `done`, `flash_en` and `port_req` are 0 and `err_code` is 0 (no error).
- R2: An enable request (`en_req` with `en_val`=1) while `access_ok` is 0 issues no port transaction, does not raise `busy`, and completes on the next cycle with `err_code`=1 (refused).
- R3: An accepted enable request issues, in order, an address write of `CTRL_IDX`, a data write of 0x02, then a data write of 0x01. `port_op` is 0 for an address write, 1 for a data write and 2 for a data read, and a request holds op and byte stable until acknowledged.
- R4: After the second keycode is acknowledged, `busy` stays high for `SETTLE_CYCLES` cycles. `done` then pulses one cycle later with `err_code`=0, and `flash_en` rises with that pulse.
- R5: A disable request (`en_req` with `en_val`=0) clears `flash_en`, issues no port transaction, and completes the next cycle with `err_code`=0. No port request is raised while `busy` is low.
- R6: An erase request while `flash_en` is 0 issues no port transaction and completes the next cycle with `err_code`=3 (not enabled).
- R7: An accepted erase issues an address write of `DATA_IDX` and a data write of `CMD_ERASE`. It then waits for `tgt_in_busy` low, waits for `tgt_out_ready` high, and issues one data read.
- R8: If the byte read is not `STAT_OK`, the erase ends with `err_code`=1 and no further port transaction.
- R9: After a good status, data writes of 0xDE, 0xAD and 0xA5 follow in that order, each followed by a wait for `tgt_in_busy` low. A final wait for `tgt_out_ready` ends the erase with `err_code`=0.
- R10: A poll whose condition stays false for `POLL_LIMIT` consecutive cycles ends the request with `err_code`=2 (timeout) and returns to idle.
- R11: Enable and erase requests arriving while `busy` is high are ignored; `en_req` has priority over `erase_req` when both arrive in the same idle cycle.
- R12: `done` is a single-cycle pulse and it coincides with every falling edge of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_ok | input | 1 | Target debug access has been granted |
| en_req | input | 1 | Enable/disable request pulse |
| en_val | input | 1 | 1 = enable flash access, 0 = disable |
| erase_req | input | 1 | Device erase request pulse |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result of last request: 0 ok, 1 refused/bad status, 2 timeout, 3 not enabled |
| flash_en | output | 1 | Flash programming access is enabled |
| port_req | output | 1 | Port primitive requested |
| port_op | output | 2 | Primitive: 0 address write, 1 data write, 2 data read |
| port_wdata | output | 8 | Byte for write primitives |
| port_ack | input | 1 | Port completed the current primitive |
| port_rdata | input | 8 | Byte returned by a read, valid with `port_ack` |
| tgt_in_busy | input | 1 | Target has not yet consumed the last data byte |
| tgt_out_ready | input | 1 | Target has a result available |

## Verification
A wrong step pointer shows up at the port within one cycle as the wrong op or byte on `port_req`. A wrong poll or settle counter moves the `done` pulse away from the cycle an independent model predicts. Because the model is compared with every output on every clock, a lost `flash_en` update or a stale result code is flagged at the first completion where it differs. A sequencer that leaks transactions when idle or after an abort is caught by the recorded transaction list of each request.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [2:0] {
    ST_WAR    = 3'd0,
    ST_WDR    = 3'd1,
    ST_RDR    = 3'd2,
    ST_PIN    = 3'd3,
    ST_POUT   = 3'd4,
    ST_WAIT   = 3'd5,
    ST_FIN_EN = 3'd6,
    ST_FIN_ER = 3'd7
  } step_e;

  localparam int unsigned PC_W = 5;
  localparam logic [PC_W-1:0] PC_ENABLE = 5'd0;
  localparam logic [PC_W-1:0] PC_ERASE  = 5'd5;

  localparam logic [1:0] OP_WADDR = 2'd0;
  localparam logic [1:0] OP_WDATA = 2'd1;
  localparam logic [1:0] OP_RDATA = 2'd2;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_BUSY  = 2'd1;
  localparam logic [1:0] RES_TMO   = 2'd2;
  localparam logic [1:0] RES_NOEN  = 2'd3;

  localparam logic [7:0] KEY_FIRST  = 8'h02;
  localparam logic [7:0] KEY_SECOND = 8'h01;
  localparam logic [7:0] ARM_0      = 8'hDE;
  localparam logic [7:0] ARM_1      = 8'hAD;
  localparam logic [7:0] ARM_2      = 8'hA5;

endpackage

// File: rtl/fes_step_rom.sv
module fes_step_rom
  import fes_pkg::*;
#(
  parameter logic [7:0] CTRL_IDX  = 8'h02,
  parameter logic [7:0] DATA_IDX  = 8'hB4,
  parameter logic [7:0] CMD_ERASE = 8'h03
) (
  input  logic [PC_W-1:0] pc,
  output step_e           kind,
  output logic [7:0]      arg
);

  always_comb begin
    kind = ST_FIN_ER;
    arg  = 8'h00;
    unique case (pc)
      5'd0:  begin kind = ST_WAR;    arg = CTRL_IDX;   end
      5'd1:  begin kind = ST_WDR;    arg = KEY_FIRST;  end
      5'd2:  begin kind = ST_WDR;    arg = KEY_SECOND; end
      5'd3:  begin kind = ST_WAIT;                     end
      5'd4:  begin kind = ST_FIN_EN;                   end
      5'd5:  begin kind = ST_WAR;    arg = DATA_IDX;   end
      5'd6:  begin kind = ST_WDR;    arg = CMD_ERASE;  end
      5'd7:  begin kind = ST_PIN;                      end
      5'd8:  begin kind = ST_POUT;                     end
      5'd9:  begin kind = ST_RDR;                      end
      5'd10: begin kind = ST_WDR;    arg = ARM_0;      end
      5'd11: begin kind = ST_PIN;                      end
      5'd12: begin kind = ST_WDR;    arg = ARM_1;      end
      5'd13: begin kind = ST_PIN;                      end
      5'd14: begin kind = ST_WDR;    arg = ARM_2;      end
      5'd15: begin kind = ST_PIN;                      end
      5'd16: begin kind = ST_POUT;                     end
      default: begin kind = ST_FIN_ER;                 end
    endcase
  end

endmodule

// File: rtl/fes_cycle_cnt.sv
module fes_cycle_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || en)  cnt <= cnt_d;
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2_500_000,
  parameter int unsigned POLL_LIMIT    = 1024,
  parameter logic [7:0]  CTRL_IDX      = 8'h02,
  parameter logic [7:0]  DATA_IDX      = 8'hB4,
  parameter logic [7:0]  CMD_ERASE     = 8'h03,
  parameter logic [7:0]  STAT_OK       = 8'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       access_ok,
  input  logic       en_req,
  input  logic       en_val,
  input  logic       erase_req,
  output logic       busy,
  output logic       done,
  output logic [1:0] err_code,
  output logic       flash_en,
  output logic       port_req,
  output logic [1:0] port_op,
  output logic [7:0] port_wdata,
  input  logic       port_ack,
  input  logic [7:0] port_rdata,
  input  logic       tgt_in_busy,
  input  logic       tgt_out_ready
);

  localparam int unsigned CNT_MAX = (SETTLE_CYCLES > POLL_LIMIT) ? SETTLE_CYCLES : POLL_LIMIT;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] POLL_LAST   = CNT_W'(POLL_LIMIT - 1);

  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [1:0]      err_q, err_d;
  logic            fen_q, fen_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            adv;
  logic            state_ce;
  logic            cnt_en;
  logic [CNT_W-1:0] cnt;
  step_e           kind;
  logic [7:0]      arg;

  fes_step_rom #(
    .CTRL_IDX  (CTRL_IDX),
    .DATA_IDX  (DATA_IDX),
    .CMD_ERASE (CMD_ERASE)
  ) rom_i (
    .pc   (pc_q),
    .kind (kind),
    .arg  (arg)
  );

  assign cnt_en = busy_q && (kind == ST_PIN || kind == ST_POUT || kind == ST_WAIT);

  fes_cycle_cnt #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (adv || !busy_q),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  always_comb begin
    busy_d = busy_q;
    pc_d   = pc_q;
    fen_d  = fen_q;
    err_d  = err_q;
    done_d = 1'b0;
    adv    = 1'b0;
    if (!busy_q) begin
      if (en_req) begin
        done_d = !(en_val && access_ok);
        if (en_val && access_ok) begin
          busy_d = 1'b1;
          pc_d   = PC_ENABLE;
        end else if (en_val) begin
          err_d  = RES_BUSY;
        end else begin
          fen_d  = 1'b0;
          err_d  = RES_OK;
        end
      end else if (erase_req) begin
        if (fen_q) begin
          busy_d = 1'b1;
          pc_d   = PC_ERASE;
        end else begin
          done_d = 1'b1;
          err_d  = RES_NOEN;
        end
      end
    end else begin
      unique case (kind)
        ST_WAR, ST_WDR: adv = port_ack;
        ST_RDR: begin
          if (port_ack) begin
            if (port_rdata == STAT_OK) begin
              adv = 1'b1;
            end else begin
              busy_d = 1'b0;
              done_d = 1'b1;
              err_d  = RES_BUSY;
            end
          end
        end
        ST_PIN, ST_POUT: begin
          if ((kind == ST_PIN) ? !tgt_in_busy : tgt_out_ready) begin
            adv = 1'b1;
          end else if (cnt == POLL_LAST) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            err_d  = RES_TMO;
          end
        end
        ST_WAIT: adv = (cnt == SETTLE_LAST);
        ST_FIN_EN: begin
          busy_d = 1'b0;
          done_d = 1'b1;
          err_d  = RES_OK;
          fen_d  = 1'b1;
        end
        default: begin
          busy_d = 1'b0;
          done_d = 1'b1;
          err_d  = RES_OK;
        end
      endcase
      if (adv) pc_d = pc_q + 1'b1;
    end
  end

  assign state_ce = busy_q || en_req || erase_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      fen_q  <= 1'b0;
      err_q  <= RES_OK;
    end else if (state_ce) begin
      busy_q <= busy_d;
      pc_q   <= pc_d;
      fen_q  <= fen_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign err_code   = err_q;
  assign flash_en   = fen_q;
  assign port_req   = busy_q && (kind == ST_WAR || kind == ST_WDR || kind == ST_RDR);
  assign port_op    = (kind == ST_WAR) ? OP_WADDR : (kind == ST_WDR) ? OP_WDATA : OP_RDATA;
  assign port_wdata = (kind == ST_WAR || kind == ST_WDR) ? arg : 8'h00;

endmodule

// File: rtl/fes_checker.sv
module fes_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code,
  input logic       flash_en,
  input logic       port_req,
  input logic [1:0] port_op,
  input logic [7:0] port_wdata,
  input logic       port_ack
);

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |-> busy);  // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && !port_ack) |=> (port_req && $stable(port_op) && $stable(port_wdata)));  // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R12

  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R12

  AST_EN_RISES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_en) |-> (done && err_code == 2'd0));  // R4

  AST_TMO_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> $past(busy));  // R10

  AST_NOEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd3) |-> (!$past(busy) && !flash_en));  // R6

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |-> (port_op != 2'd3));  // R7

endmodule

bind flash_erase_seq fes_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err_code   (err_code),
  .flash_en   (flash_en),
  .port_req   (port_req),
  .port_op    (port_op),
  .port_wdata (port_wdata),
  .port_ack   (port_ack)
);

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

  localparam int SETTLE = 20;
  localparam int PLIM   = 16;
  localparam logic [7:0] CIDX = 8'h02;
  localparam logic [7:0] DIDX = 8'hB4;
  localparam logic [7:0] CMDE = 8'h03;
  localparam logic [7:0] SOK  = 8'h0D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic access_ok = 1'b0, en_req = 1'b0, en_val = 1'b0, erase_req = 1'b0;
  logic busy, done, flash_en, port_req;
  logic [1:0] err_code, port_op;
  logic [7:0] port_wdata;
  logic port_ack = 1'b0;
  logic [7:0] port_rdata = 8'h00;
  logic tgt_in_busy = 1'b0, tgt_out_ready = 1'b1;

  always #5 clk = ~clk;

  flash_erase_seq #(
    .SETTLE_CYCLES (SETTLE), .POLL_LIMIT (PLIM),
    .CTRL_IDX (CIDX), .DATA_IDX (DIDX), .CMD_ERASE (CMDE), .STAT_OK (SOK)
  ) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- target emulator ----------------
  int   log_q[$];
  int   last_ack_cyc;
  int   ib_cnt = 0;
  int   ack_ph = 0;
  int   ack_dly = 1;
  bit   stuck = 1'b0;
  logic [7:0] status_byte = SOK;

  always @(negedge clk) begin
    if (ib_cnt > 0) ib_cnt--;
    port_ack   = 1'b0;
    port_rdata = 8'h00;
    if (port_req) begin
      if (ack_ph >= ack_dly) begin
        port_ack = 1'b1;
        ack_ph   = 0;
        log_q.push_back(int'(port_op) * 256 + int'(port_wdata));
        last_ack_cyc = cyc + 1;
        if (port_op == 2'd2) port_rdata = status_byte;
        if (port_op == 2'd1) ib_cnt = 3;
      end else begin
        ack_ph++;
      end
    end
    tgt_in_busy   = stuck || (ib_cnt > 0);
    tgt_out_ready = !stuck && (ib_cnt == 0);
  end

  // ---------------- reference model ----------------
  typedef struct { int k; int b; } step_t;
  step_t m_q[$];
  bit m_busy, m_done, m_fen;
  int m_err, m_cnt;

  function automatic void m_add(int k, int b);
    step_t s; s.k = k; s.b = b; m_q.push_back(s);
  endfunction

  function automatic void m_end(int code);
    m_busy = 0; m_done = 1; m_err = code; m_q.delete(); m_cnt = 0;
  endfunction

  function automatic void m_next();
    void'(m_q.pop_front()); m_cnt = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fen = 0; m_err = 0; m_cnt = 0; m_q.delete();
    end else begin
      cyc++;
      m_done = 0;
      if (!m_busy) begin
        if (en_req) begin
          if (en_val && access_ok) begin
            m_busy = 1; m_cnt = 0;
            m_add(0, CIDX); m_add(1, 8'h02); m_add(1, 8'h01); m_add(5, 0); m_add(6, 0);
          end else if (en_val) begin
            m_done = 1; m_err = 1;
          end else begin
            m_done = 1; m_err = 0; m_fen = 0;
          end
        end else if (erase_req) begin
          if (m_fen) begin
            m_busy = 1; m_cnt = 0;
            m_add(0, DIDX); m_add(1, CMDE); m_add(3, 0); m_add(4, 0); m_add(2, 0);
            m_add(1, 8'hDE); m_add(3, 0); m_add(1, 8'hAD); m_add(3, 0);
            m_add(1, 8'hA5); m_add(3, 0); m_add(4, 0); m_add(7, 0);
          end else begin
            m_done = 1; m_err = 3;
          end
        end
      end else begin
        case (m_q[0].k)
          0, 1: if (port_ack) m_next();
          2: if (port_ack) begin
               if (port_rdata == SOK) m_next(); else m_end(1);
             end
          3, 4: begin
            if ((m_q[0].k == 3) ? !tgt_in_busy : tgt_out_ready) m_next();
            else if (m_cnt == PLIM - 1) m_end(2);
            else m_cnt++;
          end
          5: if (m_cnt == SETTLE - 1) m_next(); else m_cnt++;
          6: begin m_end(0); m_fen = 1; end
          default: m_end(0);
        endcase
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_req;
      exp_req = m_busy && m_q.size() > 0 && m_q[0].k < 3;
      check(busy == m_busy, "R11 busy", busy, m_busy);
      check(done == m_done, "R12 done", done, m_done);
      check(int'(err_code) == m_err, "R8 err_code", err_code, m_err);
      check(flash_en == m_fen, "R4 flash_en", flash_en, m_fen);
      check(port_req == exp_req, "R5 port_req", port_req, exp_req);
      if (exp_req) begin
        check(int'(port_op) == m_q[0].k, "R3 port_op", port_op, m_q[0].k);
        check(int'(port_wdata) == ((m_q[0].k < 2) ? m_q[0].b : 0), "R9 port_wdata",
              port_wdata, (m_q[0].k < 2) ? m_q[0].b : 0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  int done_cyc;

  task automatic pulse_en(bit v);
    @(negedge clk); en_req = 1'b1; en_val = v;
    @(negedge clk); en_req = 1'b0;
  endtask

  task automatic pulse_erase();
    @(negedge clk); erase_req = 1'b1;
    @(negedge clk); erase_req = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    done_cyc = cyc;
    check(done == 1'b1, tag, done, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_log(string tag, int exp[$]);
    check(log_q.size() == exp.size(), tag, log_q.size(), exp.size());
    foreach (exp[i]) if (i < log_q.size()) check(log_q[i] == exp[i], tag, log_q[i], exp[i]);
  endtask

  initial begin
    int ex[$];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && flash_en == 0 && port_req == 0 && err_code == 0,
          "R1 reset", {busy, done, flash_en, port_req, err_code}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 enable without access
    log_q.delete();
    en_req = 1'b1; en_val = 1'b1; @(negedge clk); en_req = 1'b0;
    check(done == 1 && err_code == 1 && busy == 0, "R2 refused", {done, err_code}, 5);
    repeat (3) @(negedge clk);
    check(log_q.size() == 0 && flash_en == 0, "R2 no ops", log_q.size(), 0);

    // R6 erase without enable
    erase_req = 1'b1; @(negedge clk); erase_req = 1'b0;
    check(done == 1 && err_code == 3, "R6 not enabled", err_code, 3);
    repeat (3) @(negedge clk);
    check(log_q.size() == 0, "R6 no ops", log_q.size(), 0);

    // R3/R4/R11 enable with access; erase and disable during busy ignored
    access_ok = 1'b1; ack_dly = 2;
    pulse_en(1'b1);
    repeat (2) @(negedge clk);
    erase_req = 1'b1; @(negedge clk); erase_req = 1'b0;
    en_req = 1'b1; en_val = 1'b0; @(negedge clk); en_req = 1'b0;
    wait_done("R4 enable done");
    check(err_code == 0 && flash_en == 1, "R4 enabled", {flash_en, err_code}, 4);
    check(done_cyc - last_ack_cyc == SETTLE + 1, "R4 settle length",
          done_cyc - last_ack_cyc, SETTLE + 1);
    ex = '{int'(CIDX), 256 + 2, 256 + 1};
    chk_log("R3 keycode order", ex);
    check(busy == 0, "R11 no queued request", busy, 0);
    log_q.delete();

    // R7/R9 good erase
    ack_dly = 0; status_byte = SOK;
    pulse_erase();
    wait_done("R9 erase done");
    check(err_code == 0, "R9 erase ok", err_code, 0);
    ex = '{int'(DIDX), 256 + int'(CMDE), 512, 256 + 8'hDE, 256 + 8'hAD, 256 + 8'hA5};
    chk_log("R7 erase ops", ex);
    log_q.delete();

    // R11 priority: enable beats erase in same cycle (access off -> refused)
    access_ok = 1'b0;
    @(negedge clk); en_req = 1'b1; en_val = 1'b1; erase_req = 1'b1;
    @(negedge clk); en_req = 1'b0; erase_req = 1'b0;
    check(done == 1 && err_code == 1 && busy == 0, "R11 priority", err_code, 1);
    repeat (2) @(negedge clk);
    access_ok = 1'b1;

    // R8 bad status
    ack_dly = 1; status_byte = 8'h55;
    pulse_erase();
    wait_done("R8 abort done");
    check(err_code == 1, "R8 bad status", err_code, 1);
    ex = '{int'(DIDX), 256 + int'(CMDE), 512};
    chk_log("R8 no arming", ex);
    log_q.delete();

    // R10 poll timeout
    status_byte = SOK; stuck = 1'b1;
    pulse_erase();
    wait_done("R10 timeout done");
    check(err_code == 2 && busy == 0, "R10 timeout", err_code, 2);
    ex = '{int'(DIDX), 256 + int'(CMDE)};
    chk_log("R10 stops", ex);
    stuck = 1'b0;
    log_q.delete();

    // R5 disable
    pulse_en(1'b0);
    check(flash_en == 0 && err_code == 0, "R5 disabled", flash_en, 0);
    repeat (3) @(negedge clk);
    check(log_q.size() == 0, "R5 no ops", log_q.size(), 0);

    // R6 erase after disable
    pulse_erase();
    repeat (2) @(negedge clk);
    check(err_code == 3 && log_q.size() == 0, "R6 after disable", err_code, 3);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule